// File: doc/BRIEF.md
# Union-Find Component Merge Engine

This block merges pixel components of an image graph by walking a list of edges stored in ascending weight order. A union-find forest holds the components. Each vertex has four attributes: a parent pointer, a component size, a rank, and an adaptive threshold. For each edge, two find walkers run at the same time and resolve the root of each endpoint. The block then decides whether to merge the two components. If it merges them, it performs a union by rank and updates the attributes of the surviving root.

The block runs in one of two pass types. A threshold pass first resets every vertex to a component of its own. It then merges two components when the edge weight does not exceed either component's threshold. A minimum-size pass skips the reset. It walks the same edges again and joins any pair of components where either one is still below a size limit given by the caller.

After every merge, the surviving root's threshold becomes the merging edge's weight plus `k / new_size`. The weight term is valid as the new internal difference because edges arrive in ascending weight order. The caller loads the edges through a write port and reads back vertex attributes through a combinational query port.

Top module: `uf_merge_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all 0, and every vertex is its own parent with size 1 and rank 0.
- R2: A pass started with `mode`=0 (threshold pass) first sets, for every vertex v, parent=v, size=1, rank=0 and threshold=`k_const`.
- R3: In a threshold pass, an edge whose endpoints have distinct roots ra and rb causes a merge exactly when weight <= min(threshold[ra], threshold[rb]). Equality merges.
- R4: A union keeps the root of higher rank as parent. On equal ranks, the root of the edge's first endpoint (`va`) becomes the parent and its rank increases by 1. The child root's parent pointer is set to the surviving root.
- R5: After a merge, the surviving root's size is the sum of the two sizes. Its threshold is weight + floor(`k_const` / new size).
- R6: A pass started with `mode`=1 (minimum-size pass) leaves the vertex attributes unreset. It merges two distinct components exactly when either size is below `min_size`, whatever the weight.
- R7: An edge whose two endpoints already share a root changes no vertex attribute.
- R8: A find that would take more than `hop_limit` parent steps ends the pass at once with `err`=1. `err` holds until the next start, which clears it.
- R9: `start` is accepted only while `busy`=0. `busy` then stays 1 until the pass ends. `done` is a single-cycle pulse in the cycle `busy` falls, after edges 0 to `edge_count`-1 have been visited. `edge_count`=0 ends the pass with no edge visited.
- R10: While `ew_en`=1, a clock edge stores (`ew_va`, `ew_vb`, `ew_w`) as the edge at index `ew_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (accepted when idle) |
| mode | input | 1 | 0 = threshold pass, 1 = minimum-size pass |
| k_const | input | 10 | Threshold scale constant k |
| min_size | input | 5 | Size limit for the minimum-size pass |
| edge_count | input | 6 | Number of edges to visit |
| hop_limit | input | 5 | Maximum parent steps per find |
| ew_en | input | 1 | Edge write enable |
| ew_addr | input | 5 | Edge index to write |
| ew_va | input | 4 | First endpoint of written edge |
| ew_vb | input | 4 | Second endpoint of written edge |
| ew_w | input | 8 | Weight of written edge |
| q_addr | input | 4 | Vertex to query |
| q_parent | output | 4 | Parent pointer of queried vertex |
| q_size | output | 5 | Size attribute of queried vertex |
| q_rank | output | 4 | Rank of queried vertex |
| q_thr | output | 11 | Threshold of queried vertex |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass-end pulse |
| err | output | 1 | Last pass aborted on hop limit |

## Verification
One edge list is run through both pass types, and the results show which rule decided each merge.

- **Threshold pass.** Edges with equal-rank roots, unequal-rank roots and an already shared root separate the union-by-rank choice from the threshold test. A weight just above the smaller threshold shows the test uses the minimum of the two thresholds. A separate list with weight equal to the threshold confirms that the comparison is inclusive.
- **Minimum-size pass.** The same list then merges a pair of components the threshold pass rejected. It leaves a pair where both components are at or above the limit unjoined, and it leaves an internal edge untouched.
- **Hop limit and empty pass.** A tight hop limit on a two-level tree tells the abort path apart from an ordinary pass. An empty edge count shows that `err` clears and nothing else moves.

// File: rtl/uf_pkg.sv
// Shared types for the union-find merge engine.
// Assumes: nothing beyond standard SystemVerilog.
package uf_pkg;

    // Controller states of the edge walk.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_EDGE,
        ST_FIND,
        ST_DECIDE,
        ST_DIV
    } uf_state_e;

    // Pass type encoding on the mode input.
    localparam logic MODE_THRESH  = 1'b0;
    localparam logic MODE_MINSIZE = 1'b1;

endpackage

// File: rtl/uf_find.sv
// Root walker: follows parent pointers from a start vertex until it reaches a
// vertex that points to itself. It reports an error when more than hop_limit
// steps would be needed.
// Assumes: rd_par is the parent of rd_idx in the same cycle (combinational read).
// done/err are levels held until the next start.
module uf_find #(
    parameter int VW = 4,
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] node,
    input  logic [HW-1:0] hop_limit,
    output logic [VW-1:0] rd_idx,
    input  logic [VW-1:0] rd_par,
    output logic          done,
    output logic          err
);
    logic [VW-1:0] cur;
    logic [HW-1:0] hops;
    logic          walking;

    assign rd_idx = cur;

    // Step one parent pointer per cycle while walking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            hops    <= '0;
            walking <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else if (start) begin
            cur     <= node;
            hops    <= '0;
            walking <= 1'b1;
            done    <= 1'b0;
            err     <= 1'b0;
        end else if (walking) begin
            if (rd_par == cur) begin
                walking <= 1'b0;
                done    <= 1'b1;
            end else if (hops == hop_limit) begin
                walking <= 1'b0;
                done    <= 1'b1;
                err     <= 1'b1;
            end else begin
                cur  <= rd_par;
                hops <= hops + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uf_divider.sv
// Restoring integer divider: quotient = dividend / divisor. It retires one
// quotient bit per cycle, so a result takes NW cycles.
// Assumes: divisor is non-zero. fin pulses for one cycle when quotient is final.
module uf_divider #(
    parameter int NW = 10,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [NW-1:0] quotient,
    output logic          fin
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   trial;
    logic [DW:0]   diff;

    // Partial remainder shifted left with the next dividend bit.
    always_comb begin
        trial = {rem, quotient[NW-1]};
        diff  = trial - {1'b0, divisor};
    end

    // Shift/subtract iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            quotient <= '0;
            cnt      <= '0;
            run      <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                rem      <= '0;
                quotient <= dividend;
                cnt      <= CW'(NW);
                run      <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, divisor}) begin
                    rem      <= diff[DW-1:0];
                    quotient <= {quotient[NW-2:0], 1'b1};
                end else begin
                    rem      <= trial[DW-1:0];
                    quotient <= {quotient[NW-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uf_merge_engine.sv
// Union-find component merge engine. Walks a weight-ascending edge list and
// merges vertex components, either on the adaptive threshold rule (mode 0) or
// on the minimum-size rule (mode 1). Two find walkers resolve both endpoint
// roots concurrently. A union by rank then updates parent, size, rank and
// threshold of the surviving root.
// Assumes: edges are loaded in ascending weight order before a pass starts,
// and edge endpoints are below NV.
module uf_merge_engine
    import uf_pkg::*;
#(
    parameter int NV = 16,
    parameter int NE = 32,
    parameter int WW = 8,
    parameter int KW = 10,
    parameter int HW = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mode,
    input  logic [KW-1:0]            k_const,
    input  logic [$clog2(NV):0]      min_size,
    input  logic [$clog2(NE):0]      edge_count,
    input  logic [HW-1:0]            hop_limit,
    input  logic                     ew_en,
    input  logic [$clog2(NE)-1:0]    ew_addr,
    input  logic [$clog2(NV)-1:0]    ew_va,
    input  logic [$clog2(NV)-1:0]    ew_vb,
    input  logic [WW-1:0]            ew_w,
    input  logic [$clog2(NV)-1:0]    q_addr,
    output logic [$clog2(NV)-1:0]    q_parent,
    output logic [$clog2(NV):0]      q_size,
    output logic [$clog2(NV)-1:0]    q_rank,
    output logic [((WW > KW) ? WW : KW):0] q_thr,
    output logic                     busy,
    output logic                     done,
    output logic                     err
);
    localparam int VW  = $clog2(NV);
    localparam int SW  = VW + 1;
    localparam int RKW = VW;
    localparam int EAW = $clog2(NE);
    localparam int ECW = EAW + 1;
    localparam int TW  = ((WW > KW) ? WW : KW) + 1;

    // Edge memories (separate arrays for each field).
    logic [VW-1:0] ea_m [NE];
    logic [VW-1:0] eb_m [NE];
    logic [WW-1:0] ew_m [NE];

    // Vertex attribute memories.
    logic [VW-1:0]  par_m  [NV];
    logic [SW-1:0]  size_m [NV];
    logic [RKW-1:0] rank_m [NV];
    logic [TW-1:0]  thr_m  [NV];

    uf_state_e     state;
    logic          mode_q;
    logic [KW-1:0] k_q;
    logic [SW-1:0] ms_q;
    logic [ECW-1:0] ecnt_q;
    logic [HW-1:0] hl_q;
    logic [ECW-1:0] eidx;
    logic [VW-1:0] vidx;
    logic [WW-1:0] w_q;
    logic [VW-1:0] root_q, child_q;
    logic [SW-1:0] nsize_q;
    logic          bump_q;

    // Find walker interfaces.
    logic          fstart;
    logic [VW-1:0] fa_idx, fb_idx, fa_par, fb_par;
    logic          fa_done, fb_done, fa_err, fb_err;

    // Decision signals.
    logic          merge_ok, a_wins;
    logic [SW-1:0] nsize;
    logic [TW-1:0] thr_min;

    // Divider interface.
    logic          dstart;
    logic [KW-1:0] quo;
    logic          dfin;

    // Store incoming edges on the write port.
    always_ff @(posedge clk) begin
        if (ew_en) begin
            ea_m[ew_addr] <= ew_va;
            eb_m[ew_addr] <= ew_vb;
            ew_m[ew_addr] <= ew_w;
        end
    end

    // Combinational query port and parent reads for the walkers.
    always_comb begin
        q_parent = par_m[q_addr];
        q_size   = size_m[q_addr];
        q_rank   = rank_m[q_addr];
        q_thr    = thr_m[q_addr];
        fa_par   = par_m[fa_idx];
        fb_par   = par_m[fb_idx];
    end

    assign fstart = (state == ST_EDGE) && (eidx != ecnt_q);

    uf_find #(.VW(VW), .HW(HW)) u_find_a (
        .clk(clk), .rst_n(rst_n), .start(fstart),
        .node(ea_m[eidx[EAW-1:0]]), .hop_limit(hl_q),
        .rd_idx(fa_idx), .rd_par(fa_par), .done(fa_done), .err(fa_err)
    );

    uf_find #(.VW(VW), .HW(HW)) u_find_b (
        .clk(clk), .rst_n(rst_n), .start(fstart),
        .node(eb_m[eidx[EAW-1:0]]), .hop_limit(hl_q),
        .rd_idx(fb_idx), .rd_par(fb_par), .done(fb_done), .err(fb_err)
    );

    // Merge decision and union-by-rank selection from the two resolved roots.
    always_comb begin
        thr_min = (thr_m[fa_idx] < thr_m[fb_idx]) ? thr_m[fa_idx] : thr_m[fb_idx];
        nsize   = size_m[fa_idx] + size_m[fb_idx];
        a_wins  = rank_m[fa_idx] >= rank_m[fb_idx];
        if (fa_idx == fb_idx)
            merge_ok = 1'b0;
        else if (mode_q == MODE_THRESH)
            merge_ok = TW'(w_q) <= thr_min;
        else
            merge_ok = (size_m[fa_idx] < ms_q) || (size_m[fb_idx] < ms_q);
    end

    assign dstart = (state == ST_DECIDE) && merge_ok;

    uf_divider #(.NW(KW), .DW(SW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(dstart),
        .dividend(k_q), .divisor(nsize), .quotient(quo), .fin(dfin)
    );

    // Pass controller: init sweep, edge fetch, find wait, decide, update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= 1'b0;
            k_q     <= '0;
            ms_q    <= '0;
            ecnt_q  <= '0;
            hl_q    <= '0;
            eidx    <= '0;
            vidx    <= '0;
            w_q     <= '0;
            root_q  <= '0;
            child_q <= '0;
            nsize_q <= '0;
            bump_q  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    mode_q <= mode;
                    k_q    <= k_const;
                    ms_q   <= min_size;
                    ecnt_q <= (edge_count > ECW'(NE)) ? ECW'(NE) : edge_count;
                    hl_q   <= hop_limit;
                    eidx   <= '0;
                    vidx   <= '0;
                    err    <= 1'b0;
                    busy   <= 1'b1;
                    state  <= (mode == MODE_THRESH) ? ST_INIT : ST_EDGE;
                end
                ST_INIT: begin
                    vidx <= vidx + 1'b1;
                    if (vidx == VW'(NV - 1)) state <= ST_EDGE;
                end
                ST_EDGE: begin
                    if (eidx == ecnt_q) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        w_q   <= ew_m[eidx[EAW-1:0]];
                        state <= ST_FIND;
                    end
                end
                ST_FIND: if (fa_done && fb_done) begin
                    if (fa_err || fb_err) begin
                        err   <= 1'b1;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (merge_ok) begin
                        root_q  <= a_wins ? fa_idx : fb_idx;
                        child_q <= a_wins ? fb_idx : fa_idx;
                        nsize_q <= nsize;
                        bump_q  <= rank_m[fa_idx] == rank_m[fb_idx];
                        state   <= ST_DIV;
                    end else begin
                        eidx  <= eidx + 1'b1;
                        state <= ST_EDGE;
                    end
                end
                ST_DIV: if (dfin) begin
                    eidx  <= eidx + 1'b1;
                    state <= ST_EDGE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Vertex attribute writes: reset image, init sweep, and union update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) begin
                par_m[i]  <= VW'(i);
                size_m[i] <= SW'(1);
                rank_m[i] <= '0;
                thr_m[i]  <= '0;
            end
        end else if (state == ST_INIT) begin
            par_m[vidx]  <= vidx;
            size_m[vidx] <= SW'(1);
            rank_m[vidx] <= '0;
            thr_m[vidx]  <= TW'(k_q);
        end else if (state == ST_DIV && dfin) begin
            par_m[child_q] <= root_q;
            size_m[root_q] <= nsize_q;
            thr_m[root_q]  <= TW'(w_q) + TW'(quo);
            if (bump_q) rank_m[root_q] <= rank_m[root_q] + 1'b1;
        end
    end
endmodule

// File: rtl/uf_merge_chk.sv
// Protocol checker for the merge engine, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module uf_merge_chk #(
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [SW-1:0] q_size
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err));

    // R5
    size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_size != '0);
endmodule

bind uf_merge_engine uf_merge_chk #(.SW($clog2(NV) + 1)) u_merge_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .err(err), .q_size(q_size)
);

// File: tb/tb_uf_merge_engine.sv
// Directed bench for the union-find merge engine; one task per scenario.
module tb_uf_merge_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [9:0]  k_const = '0;
    logic [4:0]  min_size = '0;
    logic [5:0]  edge_count = '0;
    logic [4:0]  hop_limit = '0;
    logic        ew_en = 1'b0;
    logic [4:0]  ew_addr = '0;
    logic [3:0]  ew_va = '0, ew_vb = '0;
    logic [7:0]  ew_w = '0;
    logic [3:0]  q_addr = '0;
    logic [3:0]  q_parent;
    logic [4:0]  q_size;
    logic [3:0]  q_rank;
    logic [10:0] q_thr;
    logic        busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    uf_merge_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .k_const(k_const), .min_size(min_size), .edge_count(edge_count),
        .hop_limit(hop_limit), .ew_en(ew_en), .ew_addr(ew_addr),
        .ew_va(ew_va), .ew_vb(ew_vb), .ew_w(ew_w), .q_addr(q_addr),
        .q_parent(q_parent), .q_size(q_size), .q_rank(q_rank), .q_thr(q_thr),
        .busy(busy), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_edge(input int idx, input int a, input int b, input int w);
        @(negedge clk);
        ew_en = 1'b1; ew_addr = 5'(idx); ew_va = 4'(a); ew_vb = 4'(b); ew_w = 8'(w);
        @(negedge clk);
        ew_en = 1'b0;
    endtask

    task automatic run_pass(input bit m, input int k, input int ms, input int cnt, input int hl);
        int waited;
        @(negedge clk);
        mode = m; k_const = 10'(k); min_size = 5'(ms);
        edge_count = 6'(cnt); hop_limit = 5'(hl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R9 done pulse with busy low", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
    endtask

    task automatic get_root(input int v, output int r);
        int cur;
        cur = v;
        for (int s = 0; s < 16; s++) begin
            q_addr = 4'(cur);
            #0.1;
            if (int'(q_parent) == cur) break;
            cur = int'(q_parent);
        end
        r = cur;
    endtask

    task automatic chk_root(input int v, input int exp, input string req);
        int r;
        get_root(v, r);
        chk(r == exp, req, r, exp);
    endtask

    task automatic chk_attr(input int v, input int sz, input int rk, input int th, input string req);
        q_addr = 4'(v);
        #0.1;
        chk(int'(q_size) == sz, {req, " size"}, q_size, sz);
        chk(int'(q_rank) == rk, {req, " rank"}, q_rank, rk);
        chk(int'(q_thr) == th, {req, " threshold"}, q_thr, th);
    endtask

    // R1: idle outputs and singleton forest after reset.
    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(err == 0, "R1 err", err, 0);
        q_addr = 4'd9; #0.1;
        chk(q_parent == 4'd9 && q_size == 5'd1, "R1 vertex 9 singleton", q_parent, 9);
    endtask

    // R2, R9: threshold pass with no edges initialises every vertex.
    task automatic t_init();
        int bad;
        run_pass(1'b0, 20, 0, 0, 8);
        bad = 0;
        for (int v = 0; v < 16; v++) begin
            q_addr = 4'(v); #0.1;
            if (q_parent != 4'(v) || q_size != 5'd1 || q_rank != 4'd0 || q_thr != 11'd20) bad++;
        end
        chk(bad == 0, "R2 init vertices wrong", bad, 0);
    endtask

    // R3, R4, R5, R7, R10: threshold pass over a mixed edge list.
    task automatic t_threshold();
        put_edge(0, 6, 7, 1);
        put_edge(1, 8, 6, 2);
        put_edge(2, 10, 9, 3);
        put_edge(3, 0, 1, 5);
        put_edge(4, 2, 3, 8);
        put_edge(5, 0, 2, 16);
        put_edge(6, 1, 0, 17);
        put_edge(7, 4, 5, 30);
        put_edge(8, 6, 0, 40);
        run_pass(1'b0, 20, 0, 9, 8);
        chk(err == 0, "R8 no error", err, 0);
        chk_root(7, 6, "R4 tie keeps va root 6");
        chk_root(8, 6, "R4 higher rank root 6 wins");
        chk_root(9, 10, "R4 tie keeps va root 10");
        chk_attr(6, 3, 1, 8, "R5 root 6");
        chk_attr(10, 2, 1, 13, "R5 root 10");
        chk_root(1, 0, "R3 merge 0-1");
        chk_attr(0, 2, 1, 15, "R5 R7 root 0");
        chk_attr(2, 2, 1, 18, "R5 root 2");
        chk_root(2, 2, "R3 w 16 above min threshold 15 rejected");
        chk_root(5, 5, "R3 w 30 above threshold 20 rejected");
        chk_root(0, 0, "R3 edge 6-0 rejected");
    endtask

    // R6, R7: minimum-size pass reuses the list without re-initialising.
    task automatic t_minsize();
        run_pass(1'b1, 20, 3, 9, 8);
        chk(err == 0, "R8 no error", err, 0);
        chk_root(3, 0, "R6 small components 0 and 2 merged");
        chk_attr(0, 4, 2, 21, "R6 R5 root 0");
        chk_root(5, 4, "R6 singletons 4 and 5 merged");
        chk_attr(4, 2, 1, 40, "R6 R5 root 4");
        chk_root(6, 6, "R6 sizes 3 and 4 not below limit");
        chk_attr(10, 2, 1, 13, "R7 internal edge 10-9 unchanged");
    endtask

    // R8: a two-level tree with hop limit 1 aborts the pass.
    task automatic t_hoplimit();
        run_pass(1'b1, 20, 3, 9, 1);
        chk(err == 1, "R8 err on hop limit", err, 1);
        chk_attr(0, 4, 2, 21, "R8 state kept root 0");
        repeat (3) @(negedge clk);
        chk(err == 1, "R8 err held while idle", err, 1);
    endtask

    // R8, R9: empty pass clears err and changes nothing.
    task automatic t_empty();
        run_pass(1'b1, 20, 3, 0, 8);
        chk(err == 0, "R8 err cleared by start", err, 0);
        chk_root(3, 0, "R9 empty pass no change");
        chk_attr(4, 2, 1, 40, "R9 empty pass root 4");
    endtask

    // R3, R2: weight equal to threshold merges; one above does not.
    task automatic t_boundary();
        put_edge(0, 0, 1, 10);
        put_edge(1, 2, 3, 11);
        run_pass(1'b0, 10, 0, 2, 8);
        chk_root(1, 0, "R3 equal weight merges");
        chk_root(3, 3, "R3 weight above threshold rejected");
        chk_attr(0, 2, 1, 15, "R5 boundary root 0");
        chk_root(5, 5, "R2 reinit clears earlier merge");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_threshold();
        t_minsize();
        t_hoplimit();
        t_empty();
        t_boundary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule